// File: doc/BRIEF.md
# Segment Line Dilation and Erosion Unit

This block takes one image line of M grey-level pixels and returns, for every position, the maximum (dilation) or the minimum (erosion) of the pixels under a centred segment of odd length k. The window is clipped at both ends of the line. The result does not depend on how M relates to k. Each line is processed in three phases. During intake, the pixels are stored and a forward running extreme is built that restarts every k pixels. A backward sweep over the stored line then builds a running extreme that restarts at block ends. The last phase emits one result per pixel in natural order. Each result combines at most one entry from each running array.

The block is the same for any k. Every pixel costs three two-input compare-select operations. There is one in the forward pass, one in the backward pass and one in the merge. The block never inserts padding pixels. When a line ends part-way through a block, or when a window reaches past either end of the line, the merge selects its operands from index comparisons alone. The line length comes from the input stream, through the `in_last` flag. The segment length `k_cfg` and the operation `op_sel` (0 = dilate, 1 = erode) are plain inputs, captured with the first pixel of each line.

Both streams use valid/ready. A transfer happens on a rising edge where valid and ready are both high. `in_ready` is high only while a line is being accepted. It drops after the final pixel. `out_valid` stays high with `pix_out` and `out_last` unchanged until `out_ready` takes the word. The downstream side may stall for any number of cycles. The upstream side sees no ready until the whole previous line has been emitted.

Top module: `seg_line_dilate`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` and `out_valid` are never high together. No output is offered while a line is still being accepted.
- R3: Exactly M outputs follow each line, in increasing pixel index. `out_last` is 1 on the M-th output and only there. Once it has been transferred, `out_valid` falls and `in_ready` rises on the next cycle.
- R4: With `op_sel` = 0, output y equals the maximum of the input pixels at indices max(0, y−r) through min(M−1, y+r), where r = (k−1)/2.
- R5: With `op_sel` = 1, output y equals the minimum over the same clipped window.
- R6: With k = 1, every output equals the input pixel at the same index.
- R7: When M is less than k, all M outputs still follow R4 and R5.
- R8: When M is not a multiple of k, the outputs near the right end still follow R4 and R5, without extra cycles per line.
- R9: `k_cfg` and `op_sel` are captured with the first pixel of a line. Values present on them while later pixels of the same line are accepted have no effect on that line's outputs.
- R10: While `out_valid` is 1 and `out_ready` is 0, `pix_out` and `out_last` hold their values and `out_valid` stays 1.
- R11: An accepted pixel with `in_last` = 1 ends the line, and `in_ready` falls on the next cycle. If MAX_LEN pixels arrive without `in_last`, the MAX_LEN-th pixel ends the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| k_cfg | input | $clog2(MAX_K+1) | Segment length k, odd, 1..MAX_K |
| op_sel | input | 1 | 0 = dilation (max), 1 = erosion (min) |
| pix_in | input | W | Input pixel |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel |
| in_last | input | 1 | Marks the final pixel of the line |
| pix_out | output | W | Output pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_last | output | 1 | Marks the final output of the line |

## Verification
The stream properties assume that the upstream side keeps `k_cfg` odd and within 1..MAX_K whenever the first pixel of a line is accepted. They also assume that `in_last` is only meaningful together with `in_valid`. The stimulus always presents a legal odd k on the first pixel. It then deliberately drives other values, including ones that would give different results, on `k_cfg` and `op_sel` for the remaining pixels. The output side is stalled on a fixed pattern for half of the lines. This exercises the hold rule on many words, including the final one of each line.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  // Phase of the line engine: intake, backward sweep, emission.
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_BACK  = 2'd1,
    ST_MERGE = 2'd2
  } sdl_state_e;

endpackage

// File: rtl/sdl_pick.sv
// Two-input compare-select: larger value for dilation, smaller for erosion.
module sdl_pick #(
  parameter int W = 8
) (
  input  logic         erode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic a_less;

  always_comb begin
    a_less = (a < b);
    if (erode) y = a_less ? a : b;
    else       y = a_less ? b : a;
  end

endmodule

// File: rtl/sdl_linebuf.sv
// One line of pixel storage: synchronous write, combinational read.
module sdl_linebuf #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sdl_ctrl.sv
// Sequencer: index counter, block-phase counter, captured configuration.
module sdl_ctrl
  import sdl_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int MAX_K   = 15,
  parameter int AW      = $clog2(MAX_LEN),
  parameter int KW      = $clog2(MAX_K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [KW-1:0] k_cfg,
  input  logic          op_sel,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          in_acc,
  output logic          back_en,
  output logic          out_valid,
  output logic          out_last,
  output logic          g_restart,
  output logic          h_restart,
  output logic [AW-1:0] pos,
  output logic [AW-1:0] last_idx,
  output logic [KW-1:0] last_ph,
  output logic [KW-1:0] k_q,
  output logic          op_q
);

  sdl_state_e    state;
  logic [KW-1:0] phase;
  logic [KW-1:0] k_eff;
  logic          line_end;
  logic          at_tail;

  // The first pixel uses the live configuration; later ones use the capture.
  assign k_eff    = (pos == '0) ? k_cfg : k_q;
  assign line_end = in_last || (pos == AW'(MAX_LEN - 1));
  assign at_tail  = (pos == last_idx);

  assign in_ready  = (state == ST_LOAD);
  assign in_acc    = in_ready && in_valid;
  assign back_en   = (state == ST_BACK);
  assign out_valid = (state == ST_MERGE);
  assign out_last  = out_valid && at_tail;

  // Forward array restarts at index 0 of each block of k.
  assign g_restart = (phase == '0);
  // Backward array restarts at the line tail and at the last index of each block.
  assign h_restart = at_tail || (phase == k_q - KW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_LOAD;
      pos      <= '0;
      phase    <= '0;
      k_q      <= KW'(1);
      op_q     <= 1'b0;
      last_idx <= '0;
      last_ph  <= '0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (in_acc) begin
            if (pos == '0) begin
              k_q  <= k_cfg;
              op_q <= op_sel;
            end
            if (line_end) begin
              state    <= ST_BACK;
              last_idx <= pos;
              last_ph  <= phase;
            end else begin
              pos   <= pos + AW'(1);
              phase <= (phase == k_eff - KW'(1)) ? '0 : phase + KW'(1);
            end
          end
        end
        ST_BACK: begin
          if (pos == '0) begin
            state <= ST_MERGE;
          end else begin
            pos   <= pos - AW'(1);
            phase <= (phase == '0) ? k_q - KW'(1) : phase - KW'(1);
          end
        end
        ST_MERGE: begin
          if (out_ready) begin
            if (at_tail) begin
              state <= ST_LOAD;
              pos   <= '0;
              phase <= '0;
            end else begin
              pos <= pos + AW'(1);
            end
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/sdl_merge_sel.sv
// Chooses which forward/backward entries form output y, emulating padding
// at both line ends purely by index comparison.
module sdl_merge_sel #(
  parameter int AW = 6,
  parameter int KW = 4,
  parameter int IW = 8
) (
  input  logic [AW-1:0] y,
  input  logic [AW-1:0] last_idx,
  input  logic [KW-1:0] k,
  input  logic [KW-1:0] last_ph,
  output logic [AW-1:0] g_addr,
  output logic [AW-1:0] h_addr,
  output logic          use_g,
  output logic          use_h
);

  logic [IW-1:0] yw, r, ahead, li, pad_end;

  always_comb begin
    yw      = IW'(y);
    r       = IW'(k >> 1);
    ahead   = yw + r;
    li      = IW'(last_idx);
    // Last index of the virtual padded line (a whole number of blocks).
    pad_end = li + IW'(k) - IW'(1) - IW'(last_ph);

    g_addr = '0;
    h_addr = '0;
    use_g  = 1'b0;
    use_h  = 1'b0;

    if (yw < r) begin
      // Window clipped on the left: lies wholly in block 0, forward prefix suffices.
      use_g  = 1'b1;
      g_addr = (ahead > li) ? last_idx : AW'(ahead);
    end else begin
      use_h  = 1'b1;
      h_addr = y - AW'(k >> 1);
      if (ahead <= li) begin
        use_g  = 1'b1;
        g_addr = AW'(ahead);
      end else if (ahead <= pad_end) begin
        use_g  = 1'b1;
        g_addr = last_idx;
      end
    end
  end

endmodule

// File: rtl/seg_line_dilate.sv
module seg_line_dilate #(
  parameter int W       = 8,
  parameter int MAX_LEN = 64,
  parameter int MAX_K   = 15,
  localparam int AW     = $clog2(MAX_LEN),
  localparam int KW     = $clog2(MAX_K + 1),
  localparam int IW     = $clog2(MAX_LEN + MAX_K) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] k_cfg,
  input  logic          op_sel,
  input  logic [W-1:0]  pix_in,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_last,
  output logic [W-1:0]  pix_out,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_last
);

  logic          in_acc, back_en, g_restart, h_restart, op_q;
  logic [AW-1:0] pos, last_idx, g_addr, h_addr;
  logic [KW-1:0] last_ph, k_q;
  logic          use_g, use_h;

  logic [W-1:0]  f_rd, g_rd, h_rd;
  logic [W-1:0]  g_run, h_run;
  logic [W-1:0]  g_step, h_step, m_pick;
  logic [W-1:0]  g_val, h_val;

  sdl_ctrl #(
    .MAX_LEN(MAX_LEN), .MAX_K(MAX_K), .AW(AW), .KW(KW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_last(in_last),
    .k_cfg(k_cfg), .op_sel(op_sel), .out_ready(out_ready),
    .in_ready(in_ready), .in_acc(in_acc), .back_en(back_en),
    .out_valid(out_valid), .out_last(out_last),
    .g_restart(g_restart), .h_restart(h_restart),
    .pos(pos), .last_idx(last_idx), .last_ph(last_ph),
    .k_q(k_q), .op_q(op_q)
  );

  // Forward pass, computed while the line streams in.
  sdl_pick #(.W(W)) u_pick_fwd (.erode(op_q), .a(g_run), .b(pix_in), .y(g_step));
  assign g_val = g_restart ? pix_in : g_step;

  // Backward pass over the stored line.
  sdl_pick #(.W(W)) u_pick_bwd (.erode(op_q), .a(h_run), .b(f_rd), .y(h_step));
  assign h_val = h_restart ? f_rd : h_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_run <= '0;
      h_run <= '0;
    end else begin
      if (in_acc)  g_run <= g_val;
      if (back_en) h_run <= h_val;
    end
  end

  sdl_linebuf #(.W(W), .DEPTH(MAX_LEN), .AW(AW)) u_buf_f (
    .clk(clk), .we(in_acc), .waddr(pos), .wdata(pix_in), .raddr(pos), .rdata(f_rd)
  );
  sdl_linebuf #(.W(W), .DEPTH(MAX_LEN), .AW(AW)) u_buf_g (
    .clk(clk), .we(in_acc), .waddr(pos), .wdata(g_val), .raddr(g_addr), .rdata(g_rd)
  );
  sdl_linebuf #(.W(W), .DEPTH(MAX_LEN), .AW(AW)) u_buf_h (
    .clk(clk), .we(back_en), .waddr(pos), .wdata(h_val), .raddr(h_addr), .rdata(h_rd)
  );

  sdl_merge_sel #(.AW(AW), .KW(KW), .IW(IW)) u_sel (
    .y(pos), .last_idx(last_idx), .k(k_q), .last_ph(last_ph),
    .g_addr(g_addr), .h_addr(h_addr), .use_g(use_g), .use_h(use_h)
  );

  // Merge: third compare-select per pixel.
  sdl_pick #(.W(W)) u_pick_merge (.erode(op_q), .a(g_rd), .b(h_rd), .y(m_pick));

  always_comb begin
    if (use_g && use_h) pix_out = m_pick;
    else if (use_g)     pix_out = g_rd;
    else                pix_out = h_rd;
  end

endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic [W-1:0] pix_out,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_last
);

  // R2: intake and emission never overlap
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R10: a stalled output word is held
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(pix_out) && $stable(out_last)));

  // R11: the final input pixel closes intake
  a_r11_close: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R3: after the last output the block returns to intake
  a_r3_return: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

  // R3: out_last only on an offered word
  a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

bind seg_line_dilate sdl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .pix_out(pix_out), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last)
);

// File: tb/seg_line_dilate_tb.sv
module seg_line_dilate_tb;

  localparam int W       = 8;
  localparam int MAX_LEN = 64;
  localparam int MAX_K   = 15;
  localparam int KW      = $clog2(MAX_K + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [KW-1:0] k_cfg;
  logic          op_sel;
  logic [W-1:0]  pix_in;
  logic          in_valid, in_ready, in_last;
  logic [W-1:0]  pix_out;
  logic          out_valid, out_ready, out_last;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int pat [MAX_LEN];

  always #5 clk = ~clk;

  seg_line_dilate #(.W(W), .MAX_LEN(MAX_LEN), .MAX_K(MAX_K)) u_dut (
    .clk(clk), .rst_n(rst_n), .k_cfg(k_cfg), .op_sel(op_sel),
    .pix_in(pix_in), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .pix_out(pix_out), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog R3: actual=hang expected=line completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Clipped sliding-window extreme, straight from R4/R5.
  function automatic int window_ref(input int y, input int m, input int k, input bit erode);
    int r  = (k - 1) / 2;
    int lo = (y - r < 0) ? 0 : y - r;
    int hi = (y + r > m - 1) ? m - 1 : y + r;
    int v  = pat[lo];
    for (int i = lo + 1; i <= hi; i++) begin
      if (erode) v = (pat[i] < v) ? pat[i] : v;
      else       v = (pat[i] > v) ? pat[i] : v;
    end
    return v;
  endfunction

  task automatic run_line(input int k, input int m, input bit erode, input int seed,
                          input bit stall, input bit no_last);
    string tag;
    int    n, t, held_pix;
    bit    held, held_last, exp_last;

    for (int i = 0; i < m; i++)
      pat[i] = ((i * 53 + seed * 29 + (i * i) % 17) ^ (seed * 4)) & 255;

    if (no_last)          tag = "R11";
    else if (k == 1)      tag = "R6";
    else if (m < k)       tag = "R7";
    else if (m % k != 0)  tag = "R8";
    else if (erode)       tag = "R5";
    else                  tag = "R4";
    tag = {tag, "/R9"};

    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      pix_in   = W'(pat[i]);
      in_valid = 1'b1;
      in_last  = !no_last && (i == m - 1);
      if (i == 0) begin
        k_cfg  = KW'(k);
        op_sel = erode;
      end else begin
        k_cfg  = (i % 2 == 1) ? KW'(3) : KW'(9);
        op_sel = ~erode;
      end
      chk(!out_valid, "R2", int'(out_valid), 0);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk(!in_ready, "R11", int'(in_ready), 0);

    n = 0; t = 0; held = 1'b0; held_pix = 0; held_last = 1'b0;
    while (n < m) begin
      if (held) begin
        chk(out_valid && (int'(pix_out) == held_pix) && (out_last == held_last),
            "R10", int'(pix_out), held_pix);
        held = 1'b0;
      end
      t++;
      out_ready = stall ? ((t % 3) != 0) : 1'b1;
      if (out_valid) chk(!in_ready, "R2", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        int e = window_ref(n, m, k, erode);
        chk(int'(pix_out) == e, tag, int'(pix_out), e);
        exp_last = (n == m - 1);
        chk(out_last == exp_last, "R3", int'(out_last), int'(exp_last));
        n++;
      end else if (out_valid) begin
        held      = 1'b1;
        held_pix  = int'(pix_out);
        held_last = out_last;
      end
      @(negedge clk);
    end
    chk(in_ready && !out_valid, "R3", int'(out_valid), 0);
    out_ready = 1'b1;
  endtask

  initial begin
    int ms [10] = '{1, 2, 3, 5, 7, 8, 13, 16, 31, 64};
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    k_cfg = KW'(1); op_sel = 1'b0; pix_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

    for (int k = 1; k <= MAX_K; k += 2)
      for (int mi = 0; mi < 10; mi++)
        for (int op = 0; op < 2; op++)
          run_line(k, ms[mi], op[0], k * 7 + mi * 3 + op, mi[0], 1'b0);

    // R11: full-length line with no in_last
    run_line(5, MAX_LEN, 1'b0, 11, 1'b0, 1'b1);
    run_line(9, MAX_LEN, 1'b1, 12, 1'b1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule